// File: doc/BRIEF.md
# MSI Capture and Interrupt Aggregation Controller

This block sits behind a PCIe root port and turns inbound message-signalled interrupt writes into one level interrupt for the CPU interrupt controller. It has 256 vectors, split into eight sets of 32. Each set owns a programmable 64-bit capture address. An inbound write whose full address equals a set's capture address carries the vector number 0 to 31 as its data. That number sets one pending bit in that set. Writes that match no set, or that carry a vector number out of range, are dropped and flagged with a one-cycle error pulse.

Software uses a word-addressed register port. Per set it can read and write the capture address, the pending bits and a per-vector mask. A pending bit is cleared by writing 1 to it. Each set folds its unmasked pending bits into a sticky summary bit. The summary bit is gated by a per-set enable and a per-set interrupt enable. The summary bits are visible, and cleared by writing 1, in a global status word at bits 8 to 15. The interrupt line is the registered OR of the enabled summary bits.

Register map (byte offsets, 32-bit words; set index s = 0..7):

| Offset | Contents |
|---|---|
| 0xC00 + 16*s + 0x0 | capture address bits 31:0 |
| 0xC00 + 16*s + 0x4 | pending bits, write 1 to clear |
| 0xC00 + 16*s + 0x8 | per-vector mask (1 = vector may raise the summary) |
| 0xC80 + 4*s | capture address bits 63:32 |
| 0x180 | interrupt enable for set s at bit 8+s |
| 0x184 | summary for set s at bit 8+s, write 1 to clear |
| 0x190 | set enable for set s at bit s |

Top module: `msi_sink_ctrl`

## Requirements
- R1: An inbound write (msi_valid high) whose 64-bit address equals set s's capture address and whose data d is below 32 sets pending bit d of set s at the next clock edge. No other set changes.
- R2: All 64 address bits take part in the match. A write that differs from the capture address only in bits 63:32 sets no pending bit.
- R3: Writing a word to a set's pending register clears each pending bit whose written bit is 1. Bits written as 0 keep their value.
- R4: A pending bit is set even when its mask bit is 0.
- R5: Summary bit 8+s of 0x184 becomes 1 one edge after all three of these hold at an edge: bit s of 0x190 is 1, bit 8+s of 0x180 is 1, and set s has a pending bit whose mask bit is 1. If any of the three fails, the summary bit is not set.
- R6: Writing 1 to summary bit 8+s clears it. If the cause from R5 still holds at that edge, the bit stays 1. Otherwise it stays 0 after the clear.
- R7: irq is 1 exactly one edge after a summary bit is 1 while its interrupt enable and set enable are both 1. It is 0 one edge after no such bit exists.
- R8: An inbound write whose address matches no set, or whose data is 32 or above, changes no pending bit. It drives msi_err high for exactly the next clock cycle.
- R9: If an inbound write sets a pending bit in the same cycle as a software write of 1 to that bit, the bit stays 1.
- R10: Capture address halves, masks and enables read back as written. Bits 7:0 and 31:16 of 0x180 and 0x184, bits 31:8 of 0x190, and unmapped offsets read as 0.
- R11: After reset all registers read 0 and irq and msi_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 12 | register byte offset, used for reads and writes |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for reg_addr, combinational |
| msi_valid | input | 1 | inbound message write valid for one cycle |
| msi_addr | input | 64 | inbound message address |
| msi_data | input | 32 | inbound message data (vector number) |
| irq | output | 1 | level interrupt to the CPU interrupt controller |
| msi_err | output | 1 | one-cycle pulse for a dropped inbound write |

## Verification
A pending bit and msi_err appear at the first edge after the inbound write. A summary bit follows one edge after its cause, and irq one edge after the summary bit. The bench drives every stimulus just after a rising edge and reads the combinational register port a nanosecond later. It steps single edges through the summary and interrupt paths, so each stage is checked both at the cycle where it must still be 0 and at the cycle where it must have changed. The sweep covers all 256 vector and set pairs.

// File: rtl/msi_sink_pkg.sv
package msi_sink_pkg;

  localparam int unsigned REG_AW     = 12;
  localparam int unsigned SUM_LSB    = 8;
  localparam int unsigned SET_STRIDE = 16;
  localparam int unsigned HI_STRIDE  = 4;

  localparam logic [REG_AW-1:0] OFS_INT_EN   = 12'h180;
  localparam logic [REG_AW-1:0] OFS_INT_ST   = 12'h184;
  localparam logic [REG_AW-1:0] OFS_SET_EN   = 12'h190;
  localparam logic [REG_AW-1:0] OFS_SET_BASE = 12'hC00;
  localparam logic [REG_AW-1:0] OFS_HI_BASE  = 12'hC80;

  localparam logic [REG_AW-1:0] FLD_ADDR_LO = 12'h0;
  localparam logic [REG_AW-1:0] FLD_PEND    = 12'h4;
  localparam logic [REG_AW-1:0] FLD_MASK    = 12'h8;

  function automatic logic [REG_AW-1:0] set_ofs(input int unsigned idx,
                                                input logic [REG_AW-1:0] fld);
    return OFS_SET_BASE + REG_AW'(idx * SET_STRIDE) + fld;
  endfunction

  function automatic logic [REG_AW-1:0] hi_ofs(input int unsigned idx);
    return OFS_HI_BASE + REG_AW'(idx * HI_STRIDE);
  endfunction

endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/msi_vec_set.sv
module msi_vec_set #(
  parameter int unsigned VEC_PER_SET = 32,
  parameter int unsigned MSI_AW      = 64,
  parameter int unsigned DW          = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_lo,
  input  logic                   wr_hi,
  input  logic                   wr_pend,
  input  logic                   wr_mask,
  input  logic [DW-1:0]          wdata,
  input  logic [MSI_AW-1:0]      in_addr,
  input  logic [VEC_PER_SET-1:0] vec_onehot,
  output logic                   addr_match,
  output logic [MSI_AW-1:0]      cap_addr_q,
  output logic [VEC_PER_SET-1:0] pend_q,
  output logic [VEC_PER_SET-1:0] mask_q,
  output logic                   active
);

  localparam int unsigned HI_W = MSI_AW - DW;

  logic [VEC_PER_SET-1:0] pend_set;
  logic [VEC_PER_SET-1:0] pend_clr;
  logic [VEC_PER_SET-1:0] pend_d;
  logic                   pend_en;

  always_comb begin
    addr_match = (in_addr == cap_addr_q);
    pend_set   = addr_match ? vec_onehot : '0;
    pend_clr   = wr_pend ? wdata[VEC_PER_SET-1:0] : '0;
    // a fresh message outranks a simultaneous software clear
    pend_d     = (pend_q & ~pend_clr) | pend_set;
    pend_en    = wr_pend | (|pend_set);
    active     = |(pend_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q <= '0;
    end else begin
      if (wr_lo) cap_addr_q[DW-1:0]     <= wdata;
      if (wr_hi) cap_addr_q[MSI_AW-1:DW] <= wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_mask) begin
      mask_q <= wdata[VEC_PER_SET-1:0];
    end
  end

endmodule

// File: rtl/msi_summary.sv
module msi_summary #(
  parameter int unsigned NUM_SETS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_int_en,
  input  logic                wr_int_st,
  input  logic                wr_set_en,
  input  logic [NUM_SETS-1:0] sum_field_wdata,
  input  logic [NUM_SETS-1:0] set_field_wdata,
  input  logic [NUM_SETS-1:0] set_active,
  output logic [NUM_SETS-1:0] int_en_q,
  output logic [NUM_SETS-1:0] set_en_q,
  output logic [NUM_SETS-1:0] sum_q,
  output logic                irq
);

  logic [NUM_SETS-1:0] cause;
  logic [NUM_SETS-1:0] sum_clr;
  logic [NUM_SETS-1:0] sum_d;
  logic                irq_d;

  always_comb begin
    cause   = set_active & int_en_q & set_en_q;
    sum_clr = wr_int_st ? sum_field_wdata : '0;
    sum_d   = cause | (sum_q & ~sum_clr);
    irq_d   = |(sum_q & int_en_q & set_en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en_q <= '0;
    end else if (wr_int_en) begin
      int_en_q <= sum_field_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_en_q <= '0;
    end else if (wr_set_en) begin
      set_en_q <= set_field_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      irq   <= 1'b0;
    end else begin
      sum_q <= sum_d;
      irq   <= irq_d;
    end
  end

endmodule

// File: rtl/msi_sink_ctrl.sv
module msi_sink_ctrl
  import msi_sink_pkg::*;
#(
  parameter int unsigned NUM_SETS    = 8,
  parameter int unsigned VEC_PER_SET = 32,
  parameter int unsigned MSI_AW      = 64,
  parameter int unsigned DW          = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              msi_valid,
  input  logic [MSI_AW-1:0] msi_addr,
  input  logic [DW-1:0]     msi_data,
  output logic              irq,
  output logic              msi_err
);

  localparam logic [DW-1:0] VEC_LIM = DW'(VEC_PER_SET);

  logic rst_sync_n;

  logic [NUM_SETS-1:0]                  wr_lo, wr_hi, wr_pend, wr_mask;
  logic [NUM_SETS-1:0]                  addr_match;
  logic [NUM_SETS-1:0]                  set_active;
  logic [NUM_SETS-1:0][MSI_AW-1:0]      cap_addr;
  logic [NUM_SETS-1:0][VEC_PER_SET-1:0] pend;
  logic [NUM_SETS-1:0][VEC_PER_SET-1:0] mask;
  logic [NUM_SETS-1:0][DW-1:0]          set_rdata;

  logic [NUM_SETS-1:0] int_en_q, set_en_q, sum_q;
  logic [VEC_PER_SET-1:0] vec_onehot;
  logic data_ok;
  logic err_d, err_q;
  logic wr_int_en, wr_int_st, wr_set_en;

  msi_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // vector decode shared by all sets; zero unless the message is usable
  always_comb begin
    data_ok = (msi_data < VEC_LIM);
    for (int b = 0; b < VEC_PER_SET; b++) begin
      vec_onehot[b] = msi_valid && data_ok && (msi_data == DW'(b));
    end
  end

  for (genvar i = 0; i < NUM_SETS; i++) begin : g_set
    localparam logic [REG_AW-1:0] A_LO = set_ofs(i, FLD_ADDR_LO);
    localparam logic [REG_AW-1:0] A_PD = set_ofs(i, FLD_PEND);
    localparam logic [REG_AW-1:0] A_MK = set_ofs(i, FLD_MASK);
    localparam logic [REG_AW-1:0] A_HI = hi_ofs(i);

    assign wr_lo[i]   = reg_wr && (reg_addr == A_LO);
    assign wr_pend[i] = reg_wr && (reg_addr == A_PD);
    assign wr_mask[i] = reg_wr && (reg_addr == A_MK);
    assign wr_hi[i]   = reg_wr && (reg_addr == A_HI);

    msi_vec_set #(
      .VEC_PER_SET (VEC_PER_SET),
      .MSI_AW      (MSI_AW),
      .DW          (DW)
    ) u_set (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_lo      (wr_lo[i]),
      .wr_hi      (wr_hi[i]),
      .wr_pend    (wr_pend[i]),
      .wr_mask    (wr_mask[i]),
      .wdata      (reg_wdata),
      .in_addr    (msi_addr),
      .vec_onehot (vec_onehot),
      .addr_match (addr_match[i]),
      .cap_addr_q (cap_addr[i]),
      .pend_q     (pend[i]),
      .mask_q     (mask[i]),
      .active     (set_active[i])
    );

    always_comb begin
      set_rdata[i] = '0;
      if (reg_addr == A_LO) begin
        set_rdata[i] = cap_addr[i][DW-1:0];
      end else if (reg_addr == A_HI) begin
        set_rdata[i] = DW'(cap_addr[i][MSI_AW-1:DW]);
      end else if (reg_addr == A_PD) begin
        set_rdata[i] = DW'(pend[i]);
      end else if (reg_addr == A_MK) begin
        set_rdata[i] = DW'(mask[i]);
      end
    end
  end

  assign wr_int_en = reg_wr && (reg_addr == OFS_INT_EN);
  assign wr_int_st = reg_wr && (reg_addr == OFS_INT_ST);
  assign wr_set_en = reg_wr && (reg_addr == OFS_SET_EN);

  msi_summary #(.NUM_SETS(NUM_SETS)) u_summary (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .wr_int_en       (wr_int_en),
    .wr_int_st       (wr_int_st),
    .wr_set_en       (wr_set_en),
    .sum_field_wdata (reg_wdata[SUM_LSB +: NUM_SETS]),
    .set_field_wdata (reg_wdata[NUM_SETS-1:0]),
    .set_active      (set_active),
    .int_en_q        (int_en_q),
    .set_en_q        (set_en_q),
    .sum_q           (sum_q),
    .irq             (irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SETS; i++) begin
      reg_rdata = reg_rdata | set_rdata[i];
    end
    if (reg_addr == OFS_INT_EN) begin
      reg_rdata[SUM_LSB +: NUM_SETS] = int_en_q;
    end else if (reg_addr == OFS_INT_ST) begin
      reg_rdata[SUM_LSB +: NUM_SETS] = sum_q;
    end else if (reg_addr == OFS_SET_EN) begin
      reg_rdata[NUM_SETS-1:0] = set_en_q;
    end
  end

  assign err_d = msi_valid && (!data_ok || !(|addr_match));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign msi_err = err_q;

endmodule

// File: rtl/msi_sink_ctrl_chk.sv
module msi_sink_ctrl_chk #(
  parameter int unsigned NUM_SETS    = 8,
  parameter int unsigned VEC_PER_SET = 32,
  parameter int unsigned DW          = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            msi_valid,
  input logic [DW-1:0]                   msi_data,
  input logic                            msi_err,
  input logic                            irq,
  input logic                            reg_wr,
  input logic [NUM_SETS-1:0]             sum_q,
  input logic [NUM_SETS-1:0]             set_active,
  input logic [NUM_SETS-1:0]             int_en_q,
  input logic [NUM_SETS-1:0]             set_en_q,
  input logic [NUM_SETS*VEC_PER_SET-1:0] pend_flat
);

  AST_ERR_HAS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    msi_err |-> $past(msi_valid)); // R8

  AST_BAD_DATA_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && (msi_data >= DW'(VEC_PER_SET))) |=> msi_err); // R8

  AST_PEND_CLEAR_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_flat) & ~pend_flat)) |-> $past(reg_wr)); // R3

  AST_IRQ_FROM_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|sum_q)); // R7

  for (genvar i = 0; i < NUM_SETS; i++) begin : g_sum
    AST_SUM_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sum_q[i]) |-> $past(set_active[i] && int_en_q[i] && set_en_q[i])); // R5
  end

endmodule

bind msi_sink_ctrl msi_sink_ctrl_chk #(
  .NUM_SETS    (NUM_SETS),
  .VEC_PER_SET (VEC_PER_SET),
  .DW          (DW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .msi_valid  (msi_valid),
  .msi_data   (msi_data),
  .msi_err    (msi_err),
  .irq        (irq),
  .reg_wr     (reg_wr),
  .sum_q      (sum_q),
  .set_active (set_active),
  .int_en_q   (int_en_q),
  .set_en_q   (set_en_q),
  .pend_flat  (pend)
);

// File: tb/msi_sink_ctrl_tb.sv
module msi_sink_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        msi_valid;
  logic [63:0] msi_addr;
  logic [31:0] msi_data;
  logic        irq;
  logic        msi_err;

  int checks;
  int failures;
  bit done;

  msi_sink_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .msi_valid (msi_valid),
    .msi_addr  (msi_addr),
    .msi_data  (msi_data),
    .irq       (irq),
    .msi_err   (msi_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [11:0] a_lo(int s);   return 12'hC00 + 12'(s * 16);     endfunction
  function automatic logic [11:0] a_pend(int s); return 12'hC04 + 12'(s * 16);     endfunction
  function automatic logic [11:0] a_mask(int s); return 12'hC08 + 12'(s * 16);     endfunction
  function automatic logic [11:0] a_hi(int s);   return 12'hC80 + 12'(s * 4);      endfunction
  function automatic logic [63:0] cap(int s);
    return {32'h0000_00F0 + 32'(s), 32'hFEE0_1000 + 32'(s * 64)};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    tick();
    reg_wr    = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic send_msi(input logic [63:0] a, input logic [31:0] d);
    msi_addr  = a;
    msi_data  = d;
    msi_valid = 1'b1;
    tick();
    msi_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    msi_valid = 1'b0; msi_addr = '0; msi_data = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R11 reset state
    chk("R11 irq", {31'b0, irq}, 32'h0);
    chk("R11 msi_err", {31'b0, msi_err}, 32'h0);
    for (int s = 0; s < 8; s++) begin
      reg_read(a_lo(s), rd);   chk("R11 addr_lo", rd, 32'h0);
      reg_read(a_hi(s), rd);   chk("R11 addr_hi", rd, 32'h0);
      reg_read(a_pend(s), rd); chk("R11 pend", rd, 32'h0);
      reg_read(a_mask(s), rd); chk("R11 mask", rd, 32'h0);
    end
    reg_read(12'h180, rd); chk("R11 int_en", rd, 32'h0);
    reg_read(12'h184, rd); chk("R11 int_st", rd, 32'h0);
    reg_read(12'h190, rd); chk("R11 set_en", rd, 32'h0);

    // R10 programming and readback
    for (int s = 0; s < 8; s++) begin
      reg_write(a_lo(s), cap(s)[31:0]);
      reg_write(a_hi(s), cap(s)[63:32]);
      reg_write(a_mask(s), 32'hFFFF_FFFF);
    end
    for (int s = 0; s < 8; s++) begin
      reg_read(a_lo(s), rd);   chk("R10 addr_lo", rd, cap(s)[31:0]);
      reg_read(a_hi(s), rd);   chk("R10 addr_hi", rd, cap(s)[63:32]);
      reg_read(a_mask(s), rd); chk("R10 mask", rd, 32'hFFFF_FFFF);
    end
    reg_read(12'h000, rd); chk("R10 unmapped", rd, 32'h0);

    // R1 / R3 sweep of every set and vector
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 32; v++) begin
        send_msi(cap(s), 32'(v));
        chk("R8 no err on hit", {31'b0, msi_err}, 32'h0);
        reg_read(a_pend(s), rd);
        chk("R1 pend bit", rd, 32'h1 << v);
        reg_read(a_pend((s + 1) % 8), rd);
        chk("R1 other set", rd, 32'h0);
        reg_write(a_pend(s), ~(32'h1 << v));
        reg_read(a_pend(s), rd);
        chk("R3 zero keeps", rd, 32'h1 << v);
        reg_write(a_pend(s), 32'h1 << v);
        reg_read(a_pend(s), rd);
        chk("R3 one clears", rd, 32'h0);
      end
    end
    chk("R5 no irq while disabled", {31'b0, irq}, 32'h0);

    // R2 upper half must match
    send_msi({cap(3)[63:32] ^ 32'h1, cap(3)[31:0]}, 32'd4);
    chk("R2 err on hi miss", {31'b0, msi_err}, 32'h1);
    reg_read(a_pend(3), rd); chk("R2 no set", rd, 32'h0);
    tick();
    chk("R8 err one cycle", {31'b0, msi_err}, 32'h0);

    // R8 out-of-range data and address miss
    send_msi(cap(2), 32'd32);
    chk("R8 err data 32", {31'b0, msi_err}, 32'h1);
    reg_read(a_pend(2), rd); chk("R8 data 32 dropped", rd, 32'h0);
    send_msi(cap(2), 32'hFFFF_FFFF);
    chk("R8 err data max", {31'b0, msi_err}, 32'h1);
    reg_read(a_pend(2), rd); chk("R8 data max dropped", rd, 32'h0);
    send_msi(64'h1234_5678_9ABC_DEF0, 32'd1);
    chk("R8 err addr miss", {31'b0, msi_err}, 32'h1);
    for (int s = 0; s < 8; s++) begin
      reg_read(a_pend(s), rd); chk("R8 miss dropped", rd, 32'h0);
    end
    tick();
    chk("R8 err cleared", {31'b0, msi_err}, 32'h0);

    // R9 message beats simultaneous clear
    send_msi(cap(4), 32'd3);
    msi_addr = cap(4); msi_data = 32'd3; msi_valid = 1'b1;
    reg_addr = a_pend(4); reg_wdata = 32'h8; reg_wr = 1'b1;
    tick();
    msi_valid = 1'b0; reg_wr = 1'b0;
    reg_read(a_pend(4), rd); chk("R9 msi wins", rd, 32'h8);
    reg_write(a_pend(4), 32'h8);
    reg_read(a_pend(4), rd); chk("R3 clear after R9", rd, 32'h0);

    // R10 reserved bits of global registers
    reg_write(12'h180, 32'hFFFF_FFFF);
    reg_write(12'h190, 32'hFFFF_FFFF);
    reg_write(12'h184, 32'hFFFF_FFFF);
    reg_read(12'h180, rd); chk("R10 int_en bits", rd, 32'h0000_FF00);
    reg_read(12'h190, rd); chk("R10 set_en bits", rd, 32'h0000_00FF);
    reg_read(12'h184, rd); chk("R10 int_st write no set", rd, 32'h0);

    // R4 / R5 / R7 masked pending, then unmask
    reg_write(a_mask(5), 32'h0);
    send_msi(cap(5), 32'd7);
    reg_read(a_pend(5), rd); chk("R4 set while masked", rd, 32'h80);
    tick(); tick();
    reg_read(12'h184, rd); chk("R5 masked no summary", rd, 32'h0);
    chk("R7 masked no irq", {31'b0, irq}, 32'h0);
    reg_write(a_mask(5), 32'h80);
    reg_read(12'h184, rd); chk("R5 not yet", rd, 32'h0);
    tick();
    reg_read(12'h184, rd); chk("R5 summary set", rd, 32'h2000);
    chk("R7 irq not yet", {31'b0, irq}, 32'h0);
    tick();
    chk("R7 irq raised", {31'b0, irq}, 32'h1);

    // R6 clear with cause still present, then without
    reg_write(12'h184, 32'h2000);
    reg_read(12'h184, rd); chk("R6 resets while cause", rd, 32'h2000);
    chk("R7 irq held", {31'b0, irq}, 32'h1);
    reg_write(a_pend(5), 32'h80);
    reg_read(a_pend(5), rd); chk("R3 pend cleared", rd, 32'h0);
    tick();
    reg_read(12'h184, rd); chk("R6 summary sticky", rd, 32'h2000);
    reg_write(12'h184, 32'h2000);
    reg_read(12'h184, rd); chk("R6 summary cleared", rd, 32'h0);
    chk("R7 irq lags clear", {31'b0, irq}, 32'h1);
    tick();
    chk("R7 irq dropped", {31'b0, irq}, 32'h0);

    // R5 gating by set enable and interrupt enable
    reg_write(12'h190, 32'h0000_00FD);
    send_msi(cap(1), 32'd2);
    tick(); tick();
    reg_read(12'h184, rd); chk("R5 set_en off", rd, 32'h0);
    chk("R7 set_en off irq", {31'b0, irq}, 32'h0);
    reg_write(12'h180, 32'h0000_FD00);
    reg_write(12'h190, 32'h0000_00FF);
    tick(); tick();
    reg_read(12'h184, rd); chk("R5 int_en off", rd, 32'h0);
    chk("R7 int_en off irq", {31'b0, irq}, 32'h0);
    reg_write(12'h180, 32'h0000_FF00);
    reg_read(12'h184, rd); chk("R5 not yet gated", rd, 32'h0);
    tick();
    reg_read(12'h184, rd); chk("R5 both enabled", rd, 32'h0200);
    tick();
    chk("R7 irq set 1", {31'b0, irq}, 32'h1);
    reg_write(a_pend(1), 32'h4);
    reg_write(12'h184, 32'h0200);
    reg_read(12'h184, rd); chk("R6 final clear", rd, 32'h0);
    tick();
    chk("R7 final irq low", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule